// File: doc/BRIEF.md
# Full-Bridge Non-Overlap Gate Sequencer

This block turns two independent PWM levels into gate commands for the two legs of a full bridge. Each leg drives a high-side P-channel device through an active-low gate line (`pgate_n`, low means conducting) and a low-side N-channel device through an active-high gate line (`ngate`). The block never turns on one device of a leg in the same step that turns off the other. It first releases the conducting device, holds both devices off for a dead time, and only then turns on the other device.

The sequencing is asymmetric. A rising PWM releases the P gate first and raises the N gate after the rising dead time. A falling PWM drops the N gate first and lowers the P gate after the separate falling dead time. Both dead times are cycle counts supplied on input ports.

Two conditions force every gate of both legs off: a supply-good input that is not asserted, and a junction-temperature code that has crossed a trip level. The temperature override has hysteresis. When both conditions clear, each leg applies a full dead time before it turns on the device that the current PWM level selects.

Top module: `fb_gate_sequencer`

## Requirements
- R1: While reset is high, and from 3 clock edges after `pwr_good` falls until it rises again, every `pgate_n` is 1 and every `ngate` is 0.
- R2: If a leg's P device is on and its PWM input goes to 1, `pgate_n` rises at the 3rd clock edge after the input changes. `ngate` rises exactly `dly_rise_cyc` edges after that.
- R3: If a leg's N device is on and its PWM input goes to 0, `ngate` falls at the 3rd clock edge after the input changes. `pgate_n` falls exactly `dly_fall_cyc` edges after that.
- R4: A dead-time value of 0 behaves like a value of 1. The two dead-time ports act independently of each other.
- R5: If the PWM level returns to its earlier value while a dead time is counting, the pending turn-on is cancelled. The count restarts from that edge using the dead time of the new direction.
- R6: A `temp_code` value strictly above TRIP_C (default 150, unsigned 8-bit whole degrees) forces all gates off from the 2nd clock edge after it is applied. A value equal to TRIP_C does not trip.
- R7: Once the block has tripped, the override stays active while `temp_code` is at or above RELEASE_C (default 110). It clears at the 1st edge at which the code is strictly below RELEASE_C.
- R8: When the override ends, both devices of every leg stay off for the full dead time of the current PWM level before that level's device turns on.
- R9: On no leg are `pgate_n` low and `ngate` high in the same cycle. `overlap_flag` shows that condition for each leg and stays 0.
- R10: The two legs are sequenced independently. A PWM change on one leg does not change the gates of the other leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | NUM_LEGS | PWM level per leg (asynchronous) |
| pwr_good | input | 1 | Supply-good level (asynchronous), 1 = supply adequate |
| temp_code | input | TEMP_W | Junction temperature, unsigned whole degrees C |
| dly_rise_cyc | input | CNT_W | Dead time from P release to N turn-on, in cycles |
| dly_fall_cyc | input | CNT_W | Dead time from N release to P turn-on, in cycles |
| pgate_n | output | NUM_LEGS | High-side gate command, active low |
| ngate | output | NUM_LEGS | Low-side gate command, active high |
| overlap_flag | output | NUM_LEGS | 1 when a leg has both devices commanded on |

## Verification
The assertions check on every cycle that no leg ever has both devices on. They also check that each turn-on is preceded by a cycle in which the other device was already off, that an active override leaves all gates off on the next cycle, and that the thermal latch holds inside the hysteresis band and sets above the trip level. Some properties concern exact cycle counts: the 3-cycle input latency, the exact dead-time lengths, cancellation on a PWM glitch, and the full dead time after a fault clears. A bench can only show these by comparing each leg with a reference model during directed pulse trains, threshold sweeps and supply drops.

// File: rtl/fb_gate_pkg.sv
package fb_gate_pkg;

  typedef enum logic [1:0] {
    LEG_IDLE = 2'd0,   // both devices off, dead time running
    LEG_HIGH = 2'd1,   // P device conducting
    LEG_LOW  = 2'd2    // N device conducting
  } leg_state_e;

  // dead-time count with a floor of one cycle
  function automatic int unsigned eff_delay(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

endpackage

// File: rtl/fb_sync.sv
module fb_sync #(
  parameter int   WIDTH   = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= {WIDTH{RST_VAL}};
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/fb_fault_ctl.sv
module fb_fault_ctl #(
  parameter int TEMP_W    = 8,
  parameter int TRIP_C    = 150,
  parameter int RELEASE_C = 110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_ok_s,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              force_off
);

  localparam logic [TEMP_W-1:0] TRIP_V = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] REL_V  = TEMP_W'(RELEASE_C);

  logic hot_q;

  always_ff @(posedge clk) begin
    if (rst)                    hot_q <= 1'b0;
    else if (temp_code > TRIP_V) hot_q <= 1'b1;
    else if (temp_code < REL_V)  hot_q <= 1'b0;
  end

  assign force_off = hot_q | ~pwr_ok_s;

  assert_hot_set_R6: assert property (@(posedge clk) disable iff (rst)
    (temp_code > TRIP_V) |=> hot_q);

  assert_hot_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (hot_q && temp_code >= REL_V) |=> hot_q);

endmodule

// File: rtl/fb_leg_seq.sv
module fb_leg_seq
  import fb_gate_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             force_off,
  input  logic             lvl,
  input  logic [CNT_W-1:0] td_rise,
  input  logic [CNT_W-1:0] td_fall,
  output logic             pg_n,
  output logic             ng
);

  leg_state_e       st;
  logic             tgt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   need;
  logic             wait_done;

  always_comb begin
    cnt_inc   = {1'b0, cnt} + 1'b1;
    need      = tgt ? {1'b0, td_rise} : {1'b0, td_fall};
    if (need == '0) need = 1;
    wait_done = (cnt_inc >= need);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= LEG_IDLE; pg_n <= 1'b1; ng <= 1'b0; cnt <= '0; tgt <= 1'b0;
    end else if (force_off) begin
      st <= LEG_IDLE; pg_n <= 1'b1; ng <= 1'b0; cnt <= '0; tgt <= lvl;
    end else begin
      unique case (st)
        LEG_HIGH: if (lvl) begin
          st <= LEG_IDLE; pg_n <= 1'b1; tgt <= 1'b1; cnt <= '0;
        end
        LEG_LOW: if (!lvl) begin
          st <= LEG_IDLE; ng <= 1'b0; tgt <= 1'b0; cnt <= '0;
        end
        default: begin
          if (lvl != tgt) begin
            tgt <= lvl; cnt <= '0;
          end else if (wait_done) begin
            cnt <= '0;
            if (tgt) begin st <= LEG_LOW;  ng   <= 1'b1; end
            else     begin st <= LEG_HIGH; pg_n <= 1'b0; end
          end else begin
            cnt <= cnt_inc[CNT_W-1:0];
          end
        end
      endcase
    end
  end

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    !(!pg_n && ng));

  assert_n_after_p_off_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ng) |-> $past(pg_n));

  assert_p_after_n_off_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(pg_n) |-> !$past(ng));

  assert_forced_off_R6: assert property (@(posedge clk) disable iff (rst)
    force_off |=> (pg_n && !ng));

endmodule

// File: rtl/fb_gate_sequencer.sv
module fb_gate_sequencer #(
  parameter int NUM_LEGS  = 2,
  parameter int CNT_W     = 8,
  parameter int TEMP_W    = 8,
  parameter int SYNC_LEN  = 2,
  parameter int TRIP_C    = 150,
  parameter int RELEASE_C = 110
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_LEGS-1:0] pwm_in,
  input  logic                pwr_good,
  input  logic [TEMP_W-1:0]   temp_code,
  input  logic [CNT_W-1:0]    dly_rise_cyc,
  input  logic [CNT_W-1:0]    dly_fall_cyc,
  output logic [NUM_LEGS-1:0] pgate_n,
  output logic [NUM_LEGS-1:0] ngate,
  output logic [NUM_LEGS-1:0] overlap_flag
);

  logic [NUM_LEGS-1:0] pwm_s;
  logic [0:0]          pwr_s;
  logic                force_off;

  fb_sync #(.WIDTH(NUM_LEGS), .STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_pwm_sync (
    .clk(clk), .rst(rst), .d(pwm_in), .q(pwm_s));

  fb_sync #(.WIDTH(1), .STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_pwr_sync (
    .clk(clk), .rst(rst), .d(pwr_good), .q(pwr_s));

  fb_fault_ctl #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .RELEASE_C(RELEASE_C)) u_fault (
    .clk(clk), .rst(rst), .pwr_ok_s(pwr_s[0]), .temp_code(temp_code),
    .force_off(force_off));

  genvar g;
  generate
    for (g = 0; g < NUM_LEGS; g++) begin : g_leg
      fb_leg_seq #(.CNT_W(CNT_W)) u_leg (
        .clk(clk), .rst(rst), .force_off(force_off), .lvl(pwm_s[g]),
        .td_rise(dly_rise_cyc), .td_fall(dly_fall_cyc),
        .pg_n(pgate_n[g]), .ng(ngate[g]));
      assign overlap_flag[g] = ~pgate_n[g] & ngate[g];
    end
  endgenerate

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
    overlap_flag == '0);

endmodule

// File: tb/tb_fb_gate_sequencer.sv
module tb_fb_gate_sequencer;

  localparam int NL = 2;
  localparam int CW = 8;
  localparam int TRIP = 150;
  localparam int REL  = 110;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] pwm_in = '0;
  logic          pwr_good = 1'b0;
  logic [7:0]    temp_code = 8'd25;
  logic [CW-1:0] dly_rise_cyc = 8'd5;
  logic [CW-1:0] dly_fall_cyc = 8'd7;
  logic [NL-1:0] pgate_n, ngate, overlap_flag;

  always #2.5 clk = ~clk;

  fb_gate_sequencer #(.NUM_LEGS(NL), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .pwr_good(pwr_good),
    .temp_code(temp_code), .dly_rise_cyc(dly_rise_cyc), .dly_fall_cyc(dly_fall_cyc),
    .pgate_n(pgate_n), .ngate(ngate), .overlap_flag(overlap_flag));

  int    n_tests = 0;
  int    n_fail  = 0;
  string tag     = "R1";
  bit    done    = 0;

  // reference model: per leg, which device is on (0 none, 1 P, 2 N),
  // the level being waited for, and the cycles spent waiting
  int m_on [NL];
  int m_tgt[NL];
  int m_age[NL];
  int m_pw1[NL], m_pw2[NL];
  int m_pg1, m_pg2, m_hot;

  function automatic int dly(int lv);
    int d;
    d = lv ? int'(dly_rise_cyc) : int'(dly_fall_cyc);
    return (d == 0) ? 1 : d;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) begin
        m_on[i] = 0; m_tgt[i] = 0; m_age[i] = 0; m_pw1[i] = 0; m_pw2[i] = 0;
      end
      m_pg1 = 0; m_pg2 = 0; m_hot = 0;
    end else begin
      for (int i = 0; i < NL; i++) begin
        if (!m_pg2 || m_hot) begin
          m_on[i] = 0; m_tgt[i] = m_pw2[i]; m_age[i] = 0;
        end else if (m_on[i] == 1 && m_pw2[i] == 1) begin
          m_on[i] = 0; m_tgt[i] = 1; m_age[i] = 0;
        end else if (m_on[i] == 2 && m_pw2[i] == 0) begin
          m_on[i] = 0; m_tgt[i] = 0; m_age[i] = 0;
        end else if (m_on[i] == 0) begin
          if (m_pw2[i] != m_tgt[i]) begin
            m_tgt[i] = m_pw2[i]; m_age[i] = 0;
          end else begin
            m_age[i]++;
            if (m_age[i] >= dly(m_tgt[i])) begin
              m_on[i] = m_tgt[i] ? 2 : 1; m_age[i] = 0;
            end
          end
        end
      end
      if (temp_code > TRIP) m_hot = 1;
      else if (temp_code < REL) m_hot = 0;
      m_pg2 = m_pg1; m_pg1 = pwr_good;
      for (int i = 0; i < NL; i++) begin
        m_pw2[i] = m_pw1[i]; m_pw1[i] = pwm_in[i];
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < NL; i++) begin
        bit ep, en;
        ep = (m_on[i] != 1);
        en = (m_on[i] == 2);
        n_tests++;
        if (pgate_n[i] !== ep || ngate[i] !== en) begin
          n_fail++;
          $display("FAIL %s leg%0d pgate_n=%b ngate=%b expected pgate_n=%b ngate=%b",
                   tag, i, pgate_n[i], ngate[i], ep, en);
        end
        n_tests++;
        if (overlap_flag[i] !== 1'b0) begin
          n_fail++;
          $display("FAIL R9 leg%0d overlap_flag=%b expected 0", i, overlap_flag[i]);
        end
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        while (wd < 100000 && !done) begin @(posedge clk); wd++; end
        if (!done) begin
          n_fail++;
          $display("FAIL watchdog expired");
          done = 1;
          $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    cyc(4);
    // R1: reset state
    chk(pgate_n[0], 1'b1, "R1", "reset pgate_n0");
    chk(ngate[1], 1'b0, "R1", "reset ngate1");
    rst = 1'b0;
    tag = "R1";
    pwm_in = 2'b10;
    cyc(20);
    chk(pgate_n[1], 1'b1, "R1", "no supply pgate_n1");
    chk(ngate[1], 1'b0, "R1", "no supply ngate1");

    // R8: supply comes up, full dead time before turn-on
    tag = "R8";
    pwr_good = 1'b1;
    cyc(3);
    chk(ngate[1], 1'b0, "R8", "leg1 still off after release");
    cyc(5);
    chk(ngate[1], 1'b1, "R8", "leg1 N on after rise dead time");
    cyc(2);
    chk(pgate_n[0], 1'b0, "R8", "leg0 P on after fall dead time");
    cyc(10);

    // R2 with exact timing on leg0, leg1 untouched (R10)
    tag = "R2";
    pwm_in[0] = 1'b1;
    cyc(2);
    chk(pgate_n[0], 1'b0, "R2", "P still on after 2 edges");
    cyc(1);
    chk(pgate_n[0], 1'b1, "R2", "P released at 3rd edge");
    cyc(4);
    chk(ngate[0], 1'b0, "R2", "N off before dead time ends");
    cyc(1);
    chk(ngate[0], 1'b1, "R2", "N on after rise dead time");
    chk(ngate[1], 1'b1, "R10", "leg1 unaffected");
    cyc(5);

    // R3
    tag = "R3";
    pwm_in[0] = 1'b0;
    cyc(3);
    chk(ngate[0], 1'b0, "R3", "N released at 3rd edge");
    cyc(6);
    chk(pgate_n[0], 1'b1, "R3", "P off before dead time ends");
    cyc(1);
    chk(pgate_n[0], 1'b0, "R3", "P on after fall dead time");
    cyc(5);

    // R10: independent pulse trains
    tag = "R10";
    for (int k = 0; k < 6; k++) begin
      pwm_in[0] = ~pwm_in[0]; cyc(15 + k);
      pwm_in[1] = ~pwm_in[1]; cyc(11);
    end
    cyc(20);

    // R5: glitches shorter than the dead time
    tag = "R5";
    pwm_in[0] = 1'b1; cyc(4); pwm_in[0] = 1'b0; cyc(2); pwm_in[0] = 1'b1; cyc(2);
    pwm_in[0] = 1'b0; cyc(30);
    pwm_in[1] = ~pwm_in[1]; cyc(1); pwm_in[1] = ~pwm_in[1]; cyc(30);

    // R6 / R7: thermal trip and hysteresis
    tag = "R6";
    pwm_in = 2'b01;
    cyc(20);
    temp_code = 8'd150;
    cyc(5);
    chk(ngate[0], 1'b1, "R6", "no trip at threshold");
    temp_code = 8'd151;
    cyc(1);
    chk(ngate[0], 1'b1, "R6", "still on after 1 edge");
    cyc(1);
    chk(ngate[0], 1'b0, "R6", "forced off after 2 edges");
    chk(pgate_n[1], 1'b1, "R6", "leg1 P forced off");
    tag = "R7";
    temp_code = 8'd130; cyc(10);
    temp_code = 8'd110; cyc(10);
    chk(ngate[0], 1'b0, "R7", "held off at release level");
    tag = "R8";
    temp_code = 8'd109;
    cyc(2);
    chk(ngate[0], 1'b0, "R8", "off during dead time after release");
    cyc(30);

    // R4: zero and unequal dead times
    tag = "R4";
    dly_rise_cyc = 8'd0; dly_fall_cyc = 8'd2;
    for (int k = 0; k < 4; k++) begin
      pwm_in = ~pwm_in; cyc(12);
    end
    dly_rise_cyc = 8'd9; dly_fall_cyc = 8'd0;
    for (int k = 0; k < 4; k++) begin
      pwm_in = ~pwm_in; cyc(14);
    end

    // R1: supply drop mid-run
    tag = "R1";
    pwr_good = 1'b0; cyc(3);
    chk(pgate_n[0] & pgate_n[1], 1'b1, "R1", "all P off after supply drop");
    chk(ngate[0] | ngate[1], 1'b0, "R1", "all N off after supply drop");
    tag = "R8";
    pwr_good = 1'b1; cyc(30);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule